// File: doc/BRIEF.md
# Filtered Quadrature Decoder with Index

This block turns the two phase signals and the index marker of an incremental encoder into events for a position counter. The three raw inputs pass through a two-stage synchronizer. In quadrature operation they then go through a digital glitch filter that samples on a filter tick. The tick occurs on every clock or on every second clock, set by a divide bit. The filtered phases are decoded into single-cycle count strobes and a direction bit at one, two or four counts per encoder cycle.

A direct mode bypasses the filter. In this mode the synchronized A input is a count clock and B gives the direction. The index marker is turned into a single validated pulse. The polarity of the marker can be selected. In quadrature operation the marker is accepted only while both filtered phases are at the same level. In direct mode it is taken straight from the synchronizer.

Top module: `quad_index_decoder`

## Requirements
- R1: With `mode_sel` = 2'b11, each legal single-phase change of the filtered (A,B) pair gives one `cnt_stb` pulse. `cnt_up` is 1 for the A-leading order 00→10→11→01→00 (AB written as {A,B}) and 0 for the reverse order.
- R2: With `mode_sel` = 2'b10, only changes of A count: two per encoder cycle. A rising with B low, or A falling with B high, counts up. The mirror cases count down. Changes of B give no strobe.
- R3: With `mode_sel` = 2'b01, one count per encoder cycle. It counts up on 00→10 and counts down on 10→00. All other changes give no strobe.
- R4: In quadrature modes a filtered input takes a new level only after the synchronized input has shown that level on 3 consecutive filter ticks. A shorter pulse has no effect.
- R5: With `fdiv2` = 0 the filter samples on every clock. With `fdiv2` = 1 it samples on every second clock. A 3-clock pulse is then rejected, while a long level change is still counted.
- R6: A filter sample in which A and B both change produces no count.
- R7: With `mode_sel` = 2'b00 there is no filtering. Each rising edge of the synchronized A counts once, even if the pulse lasts one clock. `cnt_up` equals B at that edge (1 = up).
- R8: In quadrature modes the index is accepted only while the filtered A and B are equal.
- R9: `idx_pos` = 1 makes a high index active. `idx_pos` = 0 makes a low index active.
- R10: `idx_stb` is a one-clock pulse, issued once per active index period. It is not issued again while the index stays active.
- R11: With `mode_sel` = 2'b00 the synchronized index is used unfiltered and regardless of A and B.
- R12: In 4x mode with `fdiv2` = 0, `cnt_stb` rises exactly 6 clock edges after a change of A is applied. The pulse lasts one clock.
- R13: While `rst` is high and just after it falls, `cnt_stb`, `cnt_up` and `idx_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 00 direct, 01 1x, 10 2x, 11 4x |
| fdiv2 | input | 1 | 1 = filter ticks on every second clock |
| idx_pos | input | 1 | 1 = index active high, 0 = active low |
| in_a | input | 1 | Raw phase A |
| in_b | input | 1 | Raw phase B |
| in_idx | input | 1 | Raw index marker |
| cnt_stb | output | 1 | One-clock count event |
| cnt_up | output | 1 | Direction of the last count, 1 = up |
| idx_stb | output | 1 | One-clock validated index pulse |

## Verification
The bench walks every phase step in both directions through each resolution. A decoder that used the wrong edge set would produce extra or missing strobes, or a wrong direction. Pulses of two and three clocks are placed on both sides of the filter threshold, and a three-clock pulse is repeated with the tick halved. An off-by-one hold counter or a tick that ignores the divide bit would let the wrong pulse through. Simultaneous phase changes are applied to catch a decoder that counts them. Several index cases are covered: a held index across two equal-phase states (catching repeat pulses), an index during unequal phases, both polarities, and a one-clock marker in direct mode, which a filtered path would lose.

// File: rtl/qd_pkg.sv
package qd_pkg;
  typedef enum logic [1:0] {
    QM_DIRECT = 2'b00,
    QM_X1     = 2'b01,
    QM_X2     = 2'b10,
    QM_X4     = 2'b11
  } qmode_t;
endpackage

// File: rtl/qd_sync.sv
module qd_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= rst_val;
      q    <= rst_val;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/qd_tick_gen.sv
module qd_tick_gen (
  input  logic clk,
  input  logic rst,
  input  logic div2,
  output logic tick
);
  logic phase;

  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= ~phase;
  end

  assign tick = ~div2 | phase;

  // R5: with the divider on, ticks never fall on two clocks in a row
  assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (rst)
    (div2 && tick) |=> (!div2 || !tick));
endmodule

// File: rtl/qd_glitch_filter.sv
module qd_glitch_filter #(
  parameter int W    = 3,
  parameter int HOLD = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
      if (rst) begin
        q[i] <= rst_val[i];
        run  <= '0;
      end else if (tick) begin
        if (d[i] == q[i]) begin
          run <= '0;
        end else if (run == LAST) begin
          q[i] <= d[i];
          run  <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end
    end

    // R4: the output only moves on a tick
    assert_hold_on_idle_R4: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(q[i]));
    // R4: a new output level is the level the input showed on the tick
    assert_follow_input_R4: assert property (@(posedge clk) disable iff (rst)
      (q[i] != $past(q[i])) |-> ($past(d[i]) == q[i]));
  end
endmodule

// File: rtl/qd_phase_decode.sv
module qd_phase_decode
  import qd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  qmode_t mode,
  input  logic   fa,
  input  logic   fb,
  input  logic   ra,
  input  logic   rb,
  output logic   stb,
  output logic   up
);
  logic pa, pb, pra;
  logic a_ch, b_ch, seq_up, hit, dir;

  always_comb begin
    a_ch   = fa ^ pa;
    b_ch   = fb ^ pb;
    seq_up = ~(pa ^ fb);
    dir    = seq_up;
    case (mode)
      QM_DIRECT: begin
        hit = ra & ~pra;
        dir = rb;
      end
      QM_X1:   hit = a_ch & ~b_ch & ~fb;
      QM_X2:   hit = a_ch & ~b_ch;
      QM_X4:   hit = a_ch ^ b_ch;
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pa  <= 1'b0;
      pb  <= 1'b0;
      pra <= 1'b0;
      stb <= 1'b0;
      up  <= 1'b0;
    end else begin
      pa  <= fa;
      pb  <= fb;
      pra <= ra;
      stb <= hit;
      if (hit) up <= dir;
    end
  end

  // R6: a sample with both phases moving gives no count
  assert_no_double_step_R6: assert property (@(posedge clk) disable iff (rst)
    (mode != QM_DIRECT && a_ch && b_ch) |=> !stb);
  // R3: in 1x mode a strobe never follows a sample with B high
  assert_x1_b_low_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == QM_X1 && fb) |=> !stb);
endmodule

// File: rtl/qd_index_qual.sv
module qd_index_qual (
  input  logic clk,
  input  logic rst,
  input  logic direct,
  input  logic pos,
  input  logic s_idx,
  input  logic f_idx,
  input  logic fa,
  input  logic fb,
  output logic stb
);
  logic lvl, active, qual, fired;

  always_comb begin
    lvl    = direct ? s_idx : f_idx;
    active = pos ? lvl : ~lvl;
    qual   = active & (direct | (fa == fb));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fired <= 1'b0;
      stb   <= 1'b0;
    end else begin
      stb <= qual & ~fired;
      if (!active)   fired <= 1'b0;
      else if (qual) fired <= 1'b1;
    end
  end

  // R10: one clock wide
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    stb |=> !stb);
  // R8: never accepted while the filtered phases differ
  assert_phase_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (!direct && (fa != fb)) |=> !stb);
endmodule

// File: rtl/quad_index_decoder.sv
module quad_index_decoder
  import qd_pkg::*;
#(
  parameter int FILT_HOLD = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic       fdiv2,
  input  logic       idx_pos,
  input  logic       in_a,
  input  logic       in_b,
  input  logic       in_idx,
  output logic       cnt_stb,
  output logic       cnt_up,
  output logic       idx_stb
);
  localparam int NIN = 3;

  qmode_t       mode;
  logic [NIN-1:0] raw_v, init_v, sync_v, filt_v;
  logic         tick;

  assign mode   = qmode_t'(mode_sel);
  assign raw_v  = {in_idx, in_b, in_a};
  assign init_v = {~idx_pos, 1'b0, 1'b0};

  qd_sync #(.W(NIN)) u_sync (
    .clk(clk), .rst(rst), .rst_val(init_v), .d(raw_v), .q(sync_v)
  );

  qd_tick_gen u_tick (
    .clk(clk), .rst(rst), .div2(fdiv2), .tick(tick)
  );

  qd_glitch_filter #(.W(NIN), .HOLD(FILT_HOLD)) u_filt (
    .clk(clk), .rst(rst), .tick(tick), .rst_val(init_v),
    .d(sync_v), .q(filt_v)
  );

  qd_phase_decode u_dec (
    .clk(clk), .rst(rst), .mode(mode),
    .fa(filt_v[0]), .fb(filt_v[1]), .ra(sync_v[0]), .rb(sync_v[1]),
    .stb(cnt_stb), .up(cnt_up)
  );

  qd_index_qual u_idx (
    .clk(clk), .rst(rst), .direct(mode == QM_DIRECT), .pos(idx_pos),
    .s_idx(sync_v[2]), .f_idx(filt_v[2]),
    .fa(filt_v[0]), .fb(filt_v[1]), .stb(idx_stb)
  );

  // R13: outputs quiet the clock after reset
  assert_reset_quiet_R13: assert property (@(posedge clk)
    rst |=> (!cnt_stb && !idx_stb));
endmodule

// File: tb/quad_index_decoder_test.sv
module quad_index_decoder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode_sel = 2'b11;
  logic fdiv2 = 1'b0, idx_pos = 1'b1;
  logic in_a = 1'b0, in_b = 1'b0, in_idx = 1'b0;
  logic cnt_stb, cnt_up, idx_stb;

  int tests = 0, fails = 0, cyc = 0;
  int stb_n = 0, idx_n = 0;
  logic last_up = 1'b0;

  always #5 clk = ~clk;

  quad_index_decoder uut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .fdiv2(fdiv2),
    .idx_pos(idx_pos), .in_a(in_a), .in_b(in_b), .in_idx(in_idx),
    .cnt_stb(cnt_stb), .cnt_up(cnt_up), .idx_stb(idx_stb)
  );

  always @(negedge clk) begin
    if (cnt_stb) begin stb_n++; last_up = cnt_up; end
    if (idx_stb) idx_n++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; tests++;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // row: {mode[1:0], a, b, count[2:0], up}
  localparam logic [7:0] VEC [26] = '{
    {2'b11,1'b1,1'b0,3'd1,1'b1}, {2'b11,1'b1,1'b1,3'd1,1'b1},
    {2'b11,1'b0,1'b1,3'd1,1'b1}, {2'b11,1'b0,1'b0,3'd1,1'b1},
    {2'b11,1'b0,1'b1,3'd1,1'b0}, {2'b11,1'b1,1'b1,3'd1,1'b0},
    {2'b11,1'b1,1'b0,3'd1,1'b0}, {2'b11,1'b0,1'b0,3'd1,1'b0},
    {2'b10,1'b1,1'b0,3'd1,1'b1}, {2'b10,1'b1,1'b1,3'd0,1'b0},
    {2'b10,1'b0,1'b1,3'd1,1'b1}, {2'b10,1'b0,1'b0,3'd0,1'b0},
    {2'b10,1'b0,1'b1,3'd0,1'b0}, {2'b10,1'b1,1'b1,3'd1,1'b0},
    {2'b10,1'b1,1'b0,3'd0,1'b0}, {2'b10,1'b0,1'b0,3'd1,1'b0},
    {2'b01,1'b1,1'b0,3'd1,1'b1}, {2'b01,1'b1,1'b1,3'd0,1'b0},
    {2'b01,1'b0,1'b1,3'd0,1'b0}, {2'b01,1'b0,1'b0,3'd0,1'b0},
    {2'b01,1'b0,1'b1,3'd0,1'b0}, {2'b01,1'b1,1'b1,3'd0,1'b0},
    {2'b01,1'b1,1'b0,3'd0,1'b0}, {2'b01,1'b0,1'b0,3'd1,1'b0},
    {2'b11,1'b1,1'b1,3'd0,1'b0}, {2'b11,1'b0,1'b0,3'd0,1'b0}
  };

  initial begin
    int base;
    string tag;
    wait_n(3);
    chk("R13 cnt_stb in reset", cnt_stb, 0);
    chk("R13 idx_stb in reset", idx_stb, 0);
    rst = 1'b0;
    wait_n(1);
    chk("R13 cnt_up after reset", cnt_up, 0);
    wait_n(10);

    for (int i = 0; i < 26; i++) begin
      tag = (i >= 24) ? "R6" : (VEC[i][7:6] == 2'b11) ? "R1" :
            (VEC[i][7:6] == 2'b10) ? "R2" : "R3";
      mode_sel = VEC[i][7:6];
      in_a = VEC[i][5];
      in_b = VEC[i][4];
      base = stb_n;
      wait_n(12);
      chk({tag, " count"}, stb_n - base, int'(VEC[i][3:1]));
      if (VEC[i][3:1] != 0) chk({tag, " direction"}, last_up, VEC[i][0]);
    end

    // R12 exact latency, 4x, AB=00 now
    mode_sel = 2'b11;
    in_a = 1'b1;
    wait_n(5);
    chk("R12 no strobe after 5 edges", cnt_stb, 0);
    wait_n(1);
    chk("R12 strobe after 6 edges", cnt_stb, 1);
    wait_n(1);
    chk("R12 strobe one clock wide", cnt_stb, 0);
    in_a = 1'b0;
    wait_n(12);

    // R4 filter threshold
    base = stb_n;
    in_a = 1'b1; wait_n(2); in_a = 1'b0; wait_n(12);
    chk("R4 two-clock pulse rejected", stb_n - base, 0);
    base = stb_n;
    in_a = 1'b1; wait_n(3); in_a = 1'b0; wait_n(12);
    chk("R4 three-clock pulse passes", stb_n - base, 2);

    // R5 divided filter tick
    fdiv2 = 1'b1;
    base = stb_n;
    in_a = 1'b1; wait_n(3); in_a = 1'b0; wait_n(20);
    chk("R5 three-clock pulse rejected at half rate", stb_n - base, 0);
    base = stb_n;
    in_a = 1'b1; wait_n(20);
    chk("R5 long level counted at half rate", stb_n - base, 1);
    in_a = 1'b0; wait_n(20);
    fdiv2 = 1'b0;

    // R7 direct mode
    mode_sel = 2'b00;
    in_b = 1'b1; wait_n(4);
    base = stb_n;
    in_a = 1'b1; wait_n(1); in_a = 1'b0; wait_n(8);
    chk("R7 one-clock A pulse counts", stb_n - base, 1);
    chk("R7 B high counts up", last_up, 1);
    in_b = 1'b0; wait_n(4);
    base = stb_n;
    in_a = 1'b1; wait_n(1); in_a = 1'b0; wait_n(8);
    chk("R7 count with B low", stb_n - base, 1);
    chk("R7 B low counts down", last_up, 0);

    // index, 4x, AB=00
    mode_sel = 2'b11; wait_n(12);
    base = idx_n;
    in_idx = 1'b1; wait_n(8); in_idx = 1'b0; wait_n(10);
    chk("R8 index with A=B accepted", idx_n - base, 1);
    in_a = 1'b1; wait_n(12);
    base = idx_n;
    in_idx = 1'b1; wait_n(8); in_idx = 1'b0; wait_n(10);
    chk("R8 index with A!=B rejected", idx_n - base, 0);
    base = idx_n;
    in_idx = 1'b1; wait_n(10);
    in_b = 1'b1; wait_n(12);
    in_a = 1'b0; wait_n(12);
    in_b = 1'b0; wait_n(12);
    in_idx = 1'b0; wait_n(10);
    chk("R10 held index gives one pulse", idx_n - base, 1);

    // R9 negative polarity
    in_idx = 1'b1; wait_n(10);
    idx_pos = 1'b0; wait_n(4);
    base = idx_n;
    in_idx = 1'b0; wait_n(8); in_idx = 1'b1; wait_n(10);
    chk("R9 low index accepted when active-low", idx_n - base, 1);
    idx_pos = 1'b1; in_idx = 1'b0; wait_n(10);
    base = idx_n;
    in_idx = 1'b1; wait_n(8);
    idx_pos = 1'b0; in_idx = 1'b1; wait_n(10);
    idx_pos = 1'b1; in_idx = 1'b0; wait_n(10);

    // R11 direct-mode index ignores phases, unfiltered
    mode_sel = 2'b00; in_a = 1'b1; in_b = 1'b0; wait_n(6);
    base = idx_n;
    in_idx = 1'b1; wait_n(1); in_idx = 1'b0; wait_n(8);
    chk("R11 one-clock index with A!=B in direct mode", idx_n - base, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule